// File: doc/BRIEF.md
# Cross Trigger Event Router

This block carries event pulses between debug and monitoring sources and their consumers through a few shared broadcast channels. Each trigger input has a mask of the channels it feeds. Each trigger output has a mask of the channels it follows. A channel is live when any enabled input drives it, or when software raises it through the application channel controls.

An output that sees a live channel latches high. It then acts as a level interrupt until software clears it by writing an acknowledge. This lets a one-cycle event, such as a counter overflow, reach an interrupt controller as a steady line.

Software reaches the unit through a simple APB-style register port. A write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high, and read data is combinational from `paddr`. All configuration writes sit behind a key-based lock. The unit leaves reset locked, so software must present the key before it can set anything up.

Top module: `xtrig_router`

## Requirements
- R1: After reset the unit is locked (bit 0 of offset 0xFB4 reads 1). Routing is disabled (offset 0x000 reads 0), every channel mask reads 0, the application channel register reads 0, and `trig_out` is all zero.
- R2: A write of 0xC5ACCE55 to offset 0xFB0 unlocks the unit, and bit 0 of 0xFB4 then reads 0. A write of any other value to 0xFB0 locks it again. While the unit is locked, writes to every other offset are ignored, including acknowledges.
- R3: Offset 0x020+4·n holds the channel mask of input n, and offset 0x0A0+4·n holds the channel mask of output n, where bit c means channel c. When input n is sampled high on a clock edge with routing enabled, every output whose mask shares a channel with input n's mask goes high at that same edge. Outputs with no shared channel stay low.
- R4: An asserted output stays high until a write to offset 0x010 has bit n set, and it clears at that write's edge. If the output's channels are still live on that edge, the output stays set.
- R5: While bit 0 of offset 0x000 is 0, no output is newly asserted by either inputs or application channels.
- R6: A write to offset 0x014 ORs its low bits into the persistent application channel register, and a write to offset 0x018 clears the bits written as 1. Offset 0x014 reads back that register. Its set bits drive their channels continuously.
- R7: A write to offset 0x01C makes the channels named in its low bits live for exactly the one clock cycle after the write edge.
- R8: Read-only status: offset 0x130 shows the raw trigger inputs and 0x134 the output latches. Offset 0x138 shows the channels driven by inputs through their masks, regardless of the enable bit. Offset 0x13C shows the live channels after the enable.
- R9: Reads of any offset not named in R1 to R8 return zero. This includes mask offsets beyond the last trigger and the write-only offsets 0x010, 0x018, 0x01C and 0xFB0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for `paddr` |
| trig_in | input | N_IN (8) | Trigger event inputs |
| trig_out | output | N_OUT (8) | Latched trigger outputs / interrupt lines |

## Verification
The bench targets several corner cases.

- **Acknowledge racing an application channel that is still set.** A design that lets the acknowledge win would drop an interrupt whose cause is still present.
- **Pulse write.** A design that holds the pulsed channel would re-latch the output after it has been acknowledged.
- **Writes while locked, acknowledges included.** A lock that guards only configuration would let a stale interrupt be cleared or routing be changed without the key.
- **An input pulse with the enable clear, and an input whose mask shares no channel with the output.** These catch routing that ignores the enable or ORs masks across triggers.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int unsigned ADDR_W = 12;
  typedef logic [ADDR_W-1:0] xt_addr_t;

  localparam xt_addr_t OFS_CTRL     = 12'h000;
  localparam xt_addr_t OFS_ACK      = 12'h010;
  localparam xt_addr_t OFS_APPSET   = 12'h014;
  localparam xt_addr_t OFS_APPCLR   = 12'h018;
  localparam xt_addr_t OFS_APPPULSE = 12'h01C;
  localparam xt_addr_t OFS_INMASK   = 12'h020;
  localparam xt_addr_t OFS_OUTMASK  = 12'h0A0;
  localparam xt_addr_t OFS_ST_TIN   = 12'h130;
  localparam xt_addr_t OFS_ST_TOUT  = 12'h134;
  localparam xt_addr_t OFS_ST_CIN   = 12'h138;
  localparam xt_addr_t OFS_ST_COUT  = 12'h13C;
  localparam xt_addr_t OFS_LOCK_KEY = 12'hFB0;
  localparam xt_addr_t OFS_LOCK_ST  = 12'hFB4;

  localparam logic [31:0] UNLOCK_KEY = 32'hC5ACCE55;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  xt_addr_t                   addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  input  logic [N_IN-1:0]            trig_in_i,
  input  logic [N_OUT-1:0]           trig_out_i,
  input  logic [N_CH-1:0]            ch_in_i,
  input  logic [N_CH-1:0]            ch_act_i,
  output logic                       en_o,
  output logic [N_IN-1:0][N_CH-1:0]  in_mask_o,
  output logic [N_OUT-1:0][N_CH-1:0] out_mask_o,
  output logic [N_CH-1:0]            app_o,
  output logic [N_CH-1:0]            pulse_o,
  output logic [N_OUT-1:0]           ack_o
);
  logic                       locked_q, locked_d;
  logic                       en_q, en_d;
  logic [N_IN-1:0][N_CH-1:0]  in_mask_q, in_mask_d;
  logic [N_OUT-1:0][N_CH-1:0] out_mask_q, out_mask_d;
  logic [N_CH-1:0]            app_q, app_d;
  logic [N_CH-1:0]            pulse_q, pulse_d;
  logic                       wr_ok;
  logic                       cfg_we;

  // next-state logic
  always_comb begin
    wr_ok    = wr_en && !locked_q;
    locked_d = locked_q;
    if (wr_en && addr == OFS_LOCK_KEY) locked_d = (wdata != UNLOCK_KEY);
    en_d = en_q;
    if (wr_ok && addr == OFS_CTRL) en_d = wdata[0];
    app_d = app_q;
    if (wr_ok && addr == OFS_APPSET) app_d = app_q | wdata[N_CH-1:0];
    if (wr_ok && addr == OFS_APPCLR) app_d = app_q & ~wdata[N_CH-1:0];
    pulse_d = (wr_ok && addr == OFS_APPPULSE) ? wdata[N_CH-1:0] : '0;
    ack_o   = (wr_ok && addr == OFS_ACK) ? wdata[N_OUT-1:0] : '0;
    in_mask_d  = in_mask_q;
    out_mask_d = out_mask_q;
    for (int n = 0; n < int'(N_IN); n++)
      if (wr_ok && addr == OFS_INMASK + xt_addr_t'(4*n)) in_mask_d[n] = wdata[N_CH-1:0];
    for (int n = 0; n < int'(N_OUT); n++)
      if (wr_ok && addr == OFS_OUTMASK + xt_addr_t'(4*n)) out_mask_d[n] = wdata[N_CH-1:0];
    cfg_we = wr_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q   <= 1'b1;
      en_q       <= 1'b0;
      in_mask_q  <= '0;
      out_mask_q <= '0;
      app_q      <= '0;
      pulse_q    <= '0;
    end else begin
      if (wr_en) locked_q <= locked_d;
      if (cfg_we) begin
        en_q       <= en_d;
        in_mask_q  <= in_mask_d;
        out_mask_q <= out_mask_d;
        app_q      <= app_d;
      end
      pulse_q <= pulse_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL:    rdata[0] = en_q;
      OFS_APPSET:  rdata[N_CH-1:0] = app_q;
      OFS_ST_TIN:  rdata[N_IN-1:0] = trig_in_i;
      OFS_ST_TOUT: rdata[N_OUT-1:0] = trig_out_i;
      OFS_ST_CIN:  rdata[N_CH-1:0] = ch_in_i;
      OFS_ST_COUT: rdata[N_CH-1:0] = ch_act_i;
      OFS_LOCK_ST: rdata[0] = locked_q;
      default: begin
        for (int n = 0; n < int'(N_IN); n++)
          if (addr == OFS_INMASK + xt_addr_t'(4*n)) rdata[N_CH-1:0] = in_mask_q[n];
        for (int n = 0; n < int'(N_OUT); n++)
          if (addr == OFS_OUTMASK + xt_addr_t'(4*n)) rdata[N_CH-1:0] = out_mask_q[n];
      end
    endcase
  end

  assign en_o       = en_q;
  assign in_mask_o  = in_mask_q;
  assign out_mask_o = out_mask_q;
  assign app_o      = app_q;
  assign pulse_o    = pulse_q;

  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_LOCK_KEY && wdata == UNLOCK_KEY) |=> !locked_q); // R2
  AST_BADKEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_LOCK_KEY && wdata != UNLOCK_KEY) |=> locked_q); // R2
  AST_LOCKED_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr != OFS_LOCK_KEY) |=>
    ($stable(en_q) && $stable(in_mask_q) && $stable(out_mask_q) && $stable(app_q))); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_q != '0) && !(wr_en && addr == OFS_APPPULSE)) |=> (pulse_q == '0)); // R7
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic [N_IN-1:0]            trig_in_i,
  input  logic [N_IN-1:0][N_CH-1:0]  in_mask_i,
  input  logic [N_OUT-1:0][N_CH-1:0] out_mask_i,
  input  logic [N_CH-1:0]            app_i,
  input  logic [N_CH-1:0]            pulse_i,
  input  logic [N_OUT-1:0]           ack_i,
  output logic [N_CH-1:0]            ch_in_o,
  output logic [N_CH-1:0]            ch_act_o,
  output logic [N_OUT-1:0]           trig_out_o
);
  logic [N_CH-1:0][N_IN-1:0] in_col;
  logic [N_CH-1:0]           ch_act;
  logic [N_OUT-1:0]          hit, out_d, out_q;

  for (genvar c = 0; c < int'(N_CH); c++) begin : g_chan
    for (genvar n = 0; n < int'(N_IN); n++) begin : g_src
      assign in_col[c][n] = in_mask_i[n][c];
    end
    assign ch_in_o[c] = |(trig_in_i & in_col[c]);
  end

  assign ch_act = en_i ? (ch_in_o | app_i | pulse_i) : '0;

  for (genvar n = 0; n < int'(N_OUT); n++) begin : g_dst
    assign hit[n] = |(ch_act & out_mask_i[n]);
  end

  always_comb out_d = (out_q & ~ack_i) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign ch_act_o   = ch_act;
  assign trig_out_o = out_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_q & ~ack_i)) |=> (((($past(out_q) & ~$past(ack_i))) & ~out_q) == '0)); // R4
  AST_DISABLED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> ((out_q & ~$past(out_q)) == '0)); // R5
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router
  import xtrig_pkg::*;
#(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_CH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [N_IN-1:0]   trig_in,
  output logic [N_OUT-1:0]  trig_out
);
  logic [1:0]                 rst_sync;
  logic                       rst_ni;
  logic                       wr_en;
  logic                       en;
  logic [N_IN-1:0][N_CH-1:0]  in_mask;
  logic [N_OUT-1:0][N_CH-1:0] out_mask;
  logic [N_CH-1:0]            app, pulse, ch_in, ch_act;
  logic [N_OUT-1:0]           ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign wr_en = psel && penable && pwrite;

  xtrig_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
    .rdata(prdata), .trig_in_i(trig_in), .trig_out_i(trig_out),
    .ch_in_i(ch_in), .ch_act_i(ch_act), .en_o(en), .in_mask_o(in_mask),
    .out_mask_o(out_mask), .app_o(app), .pulse_o(pulse), .ack_o(ack)
  );

  xtrig_route #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) u_route (
    .clk(clk), .rst_n(rst_ni), .en_i(en), .trig_in_i(trig_in),
    .in_mask_i(in_mask), .out_mask_i(out_mask), .app_i(app), .pulse_i(pulse),
    .ack_i(ack), .ch_in_o(ch_in), .ch_act_o(ch_act), .trig_out_o(trig_out)
  );
endmodule

// File: tb/xtrig_router_test.sv
`timescale 1ns/1ps
module xtrig_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [7:0]  trig_in, trig_out;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // reference model state
  bit       m_lock;
  bit       m_en;
  bit [3:0] m_in [8];
  bit [3:0] m_out[8];
  bit [3:0] m_app, m_pulse;
  bit [7:0] m_trig;

  xtrig_router uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .trig_in(trig_in), .trig_out(trig_out)
  );

  always #2.5 clk = ~clk;

  function automatic bit [3:0] m_cin();
    bit [3:0] r = 0;
    for (int i = 0; i < 8; i++) if (trig_in[i]) r |= m_in[i];
    return r;
  endfunction

  function automatic bit [3:0] m_act();
    return m_en ? (m_cin() | m_app | m_pulse) : 4'h0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r = 0;
    if (a == 12'h000) r = {31'd0, m_en};
    else if (a == 12'h014) r = {28'd0, m_app};
    else if (a == 12'h130) r = {24'd0, trig_in};
    else if (a == 12'h134) r = {24'd0, m_trig};
    else if (a == 12'h138) r = {28'd0, m_cin()};
    else if (a == 12'h13C) r = {28'd0, m_act()};
    else if (a == 12'hFB4) r = {31'd0, m_lock};
    else if (a >= 12'h020 && a < 12'h040 && a[1:0] == 2'b00) r = {28'd0, m_in[(a - 12'h020) >> 2]};
    else if (a >= 12'h0A0 && a < 12'h0C0 && a[1:0] == 2'b00) r = {28'd0, m_out[(a - 12'h0A0) >> 2]};
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 1; m_en = 0; m_app = 0; m_pulse = 0; m_trig = 0;
      for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_out[i] = 0; end
    end else begin : step
      bit       wr;
      bit [3:0] act;
      bit [7:0] hit, ack;
      wr  = psel && penable && pwrite;
      act = m_act();
      hit = 0;
      for (int i = 0; i < 8; i++) if ((act & m_out[i]) != 0) hit[i] = 1;
      ack = (wr && !m_lock && paddr == 12'h010) ? pwdata[7:0] : 8'h0;
      m_trig  = (m_trig & ~ack) | hit;
      m_pulse = 0;
      if (wr) begin
        if (paddr == 12'hFB0) m_lock = (pwdata != 32'hC5ACCE55);
        else if (!m_lock) begin
          if (paddr == 12'h000) m_en = pwdata[0];
          else if (paddr == 12'h014) m_app = m_app | pwdata[3:0];
          else if (paddr == 12'h018) m_app = m_app & ~pwdata[3:0];
          else if (paddr == 12'h01C) m_pulse = pwdata[3:0];
          else if (paddr >= 12'h020 && paddr < 12'h040 && paddr[1:0] == 0) m_in[(paddr - 12'h020) >> 2] = pwdata[3:0];
          else if (paddr >= 12'h0A0 && paddr < 12'h0C0 && paddr[1:0] == 0) m_out[(paddr - 12'h0A0) >> 2] = pwdata[3:0];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (checking && rst_n) begin
      chk({cur_tag, " trig_out vs model"}, {24'd0, trig_out}, {24'd0, m_trig});
      chk({cur_tag, " prdata vs model"}, prdata, m_read(paddr));
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(posedge clk); #1 d = prdata;
    @(negedge clk); psel = 0;
  endtask

  task automatic fire(input int idx);
    @(negedge clk); trig_in[idx] = 1'b1;
    @(negedge clk); trig_in = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; trig_in = 0;
    #23 rst_n = 1;
    repeat (5) @(negedge clk);
    checking = 1;

    cur_tag = "R1";
    chk("R1 trig_out after reset", {24'd0, trig_out}, 32'h0);
    apb_rd(12'hFB4, d); chk("R1 lock status", d, 32'h1);
    apb_rd(12'h000, d); chk("R1 control", d, 32'h0);
    apb_rd(12'h024, d); chk("R1 input mask", d, 32'h0);
    apb_rd(12'h014, d); chk("R1 app reg", d, 32'h0);

    cur_tag = "R2";
    apb_wr(12'h000, 32'h1);
    apb_wr(12'h024, 32'h4);
    apb_rd(12'h000, d); chk("R2 locked ctrl write ignored", d, 32'h0);
    apb_rd(12'h024, d); chk("R2 locked mask write ignored", d, 32'h0);
    apb_wr(12'hFB0, 32'hC5ACCE55);
    apb_rd(12'hFB4, d); chk("R2 unlocked status", d, 32'h0);

    cur_tag = "R5";
    apb_wr(12'h024, 32'h4);   // input 1 -> channel 2
    apb_wr(12'h0B8, 32'h4);   // output 6 <- channel 2
    fire(1);
    chk("R5 no routing while disabled", {24'd0, trig_out}, 32'h0);
    apb_wr(12'h014, 32'h4);
    @(negedge clk);
    chk("R5 app channel blocked while disabled", {24'd0, trig_out}, 32'h0);
    apb_wr(12'h018, 32'h4);

    cur_tag = "R3";
    apb_wr(12'h000, 32'h1);
    fire(1);
    chk("R3 routed event", {24'd0, trig_out}, 32'h40);
    cur_tag = "R4";
    repeat (4) @(negedge clk);
    chk("R4 latch holds", {24'd0, trig_out}, 32'h40);
    apb_rd(12'h134, d); chk("R8 out status", d, 32'h40);
    apb_wr(12'h010, 32'h40);
    chk("R4 ack clears", {24'd0, trig_out}, 32'h0);

    cur_tag = "R3";
    apb_wr(12'h02C, 32'h2);   // input 3 -> channel 1
    fire(3);
    chk("R3 no shared channel", {24'd0, trig_out}, 32'h0);

    cur_tag = "R8";
    @(negedge clk); trig_in = 8'h0A;
    apb_rd(12'h130, d); chk("R8 trigger-in status", d, 32'h0A);
    @(negedge clk); trig_in = 8'h0A;
    apb_rd(12'h138, d); chk("R8 channel-in status", d, 32'h6);
    @(negedge clk); trig_in = 8'h0A;
    apb_rd(12'h13C, d); chk("R8 channel-out status", d, 32'h6);
    @(negedge clk); trig_in = 8'h00;
    apb_wr(12'h010, 32'h40);
    chk("R8 cleanup ack", {24'd0, trig_out}, 32'h0);

    cur_tag = "R6";
    apb_wr(12'h014, 32'h4);
    @(negedge clk);
    chk("R6 app channel asserts output", {24'd0, trig_out}, 32'h40);
    apb_rd(12'h014, d); chk("R6 app readback", d, 32'h4);
    apb_wr(12'h010, 32'h40);
    chk("R4 live channel beats ack", {24'd0, trig_out}, 32'h40);
    apb_wr(12'h018, 32'h4);
    apb_rd(12'h014, d); chk("R6 app cleared", d, 32'h0);
    apb_wr(12'h010, 32'h40);
    chk("R6 ack after clear", {24'd0, trig_out}, 32'h0);

    cur_tag = "R7";
    apb_wr(12'h01C, 32'h4);
    @(negedge clk);
    chk("R7 pulse asserts output", {24'd0, trig_out}, 32'h40);
    apb_wr(12'h010, 32'h40);
    chk("R7 ack after pulse", {24'd0, trig_out}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R7 pulse not persistent", {24'd0, trig_out}, 32'h0);

    cur_tag = "R2";
    apb_wr(12'hFB0, 32'h0);
    apb_rd(12'hFB4, d); chk("R2 relocked", d, 32'h1);
    apb_wr(12'h000, 32'h0);
    fire(1);
    chk("R2 enable kept while locked", {24'd0, trig_out}, 32'h40);
    apb_wr(12'h010, 32'h40);
    chk("R2 ack ignored while locked", {24'd0, trig_out}, 32'h40);
    apb_wr(12'hFB0, 32'hC5ACCE55);
    apb_wr(12'h010, 32'h40);
    chk("R2 ack after unlock", {24'd0, trig_out}, 32'h0);

    cur_tag = "R9";
    apb_rd(12'h200, d); chk("R9 unmapped 0x200", d, 32'h0);
    apb_rd(12'hFFC, d); chk("R9 unmapped 0xFFC", d, 32'h0);
    apb_rd(12'h0C0, d); chk("R9 mask beyond last output", d, 32'h0);
    apb_rd(12'h01C, d); chk("R9 write-only pulse offset", d, 32'h0);

    repeat (2) @(negedge clk);
    checking = 0;
    done = 1;
    finish_run();
  end
endmodule